// File: doc/BRIEF.md
# Stream-to-Bus Register Mailbox

This block links two parties that exchange register traffic. One is a 64-bit message stream with valid/ready handshakes. The other is a local processor on a 32-bit Wishbone slave port with 16-bit addresses.

Each message carries three flag bits, a 20-bit address and a 32-bit payload. When a read or write request arrives on the stream, the block holds it in a mailbox. The processor sees it through four bus registers and answers reads by writing a control word. In the other direction, the processor places outbound writes, reads and answers into a queue that drains onto the outgoing stream, and it collects read responses that come back from the stream.

Two address windows on the stream side are served directly by the block:
- one reports whether a stream read is still waiting for the processor;
- one returns the last answer the processor gave.

Top module: `msg_wb_mailbox`

## Requirements
- R1: After reset the status word reads 0, `out_tvalid` is 0 and `in_tready` is 1.
- R2: Every bus strobe is acknowledged by a single-cycle `wb_ack` in the cycle after the strobe is first seen. Read data is valid together with that acknowledge.
- R3: An inbound write (message bit 62) sets status bit 1. The bus register at 0x4 then reads {bit 30 set, zeros, message address bits 15:0}, and 0x0 reads the payload. Reading 0x4 clears status bit 1. While bit 1 is set, `in_tready` is 0.
- R4: An inbound read (message bit 61) whose address bits 19:12 are neither 0x6A nor 0x7A sets status bits 1 and 2, so status reads 0x6. Register 0x4 then reads {bit 29 set, zeros, address bits 15:0}.
- R5: Writing only the data register at 0x0 emits nothing. Each write to 0x4 emits exactly one outbound message whose upper 32 bits are the written control word and whose lower 32 bits are the data register.
- R6: A control write with bit 31 set clears status bit 2 and records the data register as the processor's answer.
- R7: A control write with bit 29 set sets status bit 0. An inbound message with bit 63 set clears bit 0, and its payload becomes readable at 0x8.
- R8: The outbound queue holds 64 messages. When it is full, status bit 4 is set and further control writes are dropped. Bit 4 clears once the queue drains.
- R9: An inbound read with address bits 19:12 equal to 0x6A is answered on the outgoing stream with bit 63 set, bits 62:32 zero, and payload 1 if status bit 2 is set, otherwise 0.
- R10: An inbound read with address bits 19:12 equal to 0x7A is answered with bit 63 set and the last recorded answer as payload. Later inbound writes do not change that answer.
- R11: While `out_tvalid` is high and `out_tready` is low, `out_tvalid` stays high and `out_tdata` does not change.
- R12: Bus writes to 0x8 and 0xC have no effect on what those registers read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | 16 | Bus byte address |
| wb_wdat | input | 32 | Bus write data |
| wb_ack | output | 1 | Bus acknowledge |
| wb_rdat | output | 32 | Bus read data |
| in_tdata | input | 64 | Inbound message |
| in_tvalid | input | 1 | Inbound message valid |
| in_tready | output | 1 | Inbound message accepted |
| out_tdata | output | 64 | Outbound message |
| out_tvalid | output | 1 | Outbound message valid |
| out_tready | input | 1 | Outbound message taken |

## Verification
The bench builds the block with its default parameters:
- a 64-entry outbound queue;
- 32-bit bus data and 16-bit bus addresses;
- the 0x6A and 0x7A stream windows.

With a 64-entry queue, a directed burst of 66 control writes against a stalled stream fills the queue and drops the last two writes. The bench can then check the full flag and the exact number of messages that drain. Random mixes of inbound requests, processor answers and outbound requests run under random output back-pressure, so the ordering between queued messages and window responses is exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // status word bit positions
  localparam int ST_OUT_RD  = 0;
  localparam int ST_IN_REQ  = 1;
  localparam int ST_IN_WAIT = 2;
  localparam int ST_Q_FULL  = 4;

  // bus register selector (address bits 3:2)
  typedef enum logic [1:0] {
    REG_DATA  = 2'd0,
    REG_CTRL  = 2'd1,
    REG_RDATA = 2'd2,
    REG_STAT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage has no reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/mbx_in_decode.sv
module mbx_in_decode #(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int MAW      = 20,
  parameter int WIN_W    = 8,
  parameter logic [WIN_W-1:0] STAT_WIN = 8'h6A,
  parameter logic [WIN_W-1:0] DATA_WIN = 8'h7A
) (
  input  logic [2*DW-1:0] msg,
  output logic            is_resp,
  output logic            is_wr,
  output logic            is_rd,
  output logic            hit_stat,
  output logic            hit_data,
  output logic [DW-1:0]   ctrl
);
  localparam int MW = 2 * DW;

  logic [MAW-1:0]   addr;
  logic [WIN_W-1:0] win;

  assign addr     = msg[DW +: MAW];
  assign win      = addr[MAW-1 -: WIN_W];
  assign is_resp  = msg[MW-1];
  assign is_wr    = msg[MW-2];
  assign is_rd    = msg[MW-3];
  assign hit_stat = (win == STAT_WIN);
  assign hit_data = (win == DATA_WIN);
  // control word presented to the processor: flags, zeros, local offset
  assign ctrl     = {msg[MW-1 -: 3], {(DW-3-AW){1'b0}}, addr[AW-1:0]};
endmodule

// File: rtl/msg_wb_mailbox.sv
module msg_wb_mailbox
  import mbx_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 16,
  parameter int MAW      = 20,
  parameter int Q_DEPTH  = 64,
  parameter logic [7:0] STAT_WIN = 8'h6A,
  parameter logic [7:0] DATA_WIN = 8'h7A
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wb_stb,
  input  logic            wb_we,
  input  logic [AW-1:0]   wb_adr,
  input  logic [DW-1:0]   wb_wdat,
  output logic            wb_ack,
  output logic [DW-1:0]   wb_rdat,
  input  logic [2*DW-1:0] in_tdata,
  input  logic            in_tvalid,
  output logic            in_tready,
  output logic [2*DW-1:0] out_tdata,
  output logic            out_tvalid,
  input  logic            out_tready
);
  localparam int MW = 2 * DW;

  // inbound decode
  logic d_resp, d_wr, d_rd, d_stat, d_data;
  logic [DW-1:0] d_ctrl;

  mbx_in_decode #(
    .DW(DW), .AW(AW), .MAW(MAW), .WIN_W(8),
    .STAT_WIN(STAT_WIN), .DATA_WIN(DATA_WIN)
  ) dec_i (
    .msg(in_tdata), .is_resp(d_resp), .is_wr(d_wr), .is_rd(d_rd),
    .hit_stat(d_stat), .hit_data(d_data), .ctrl(d_ctrl)
  );

  // state
  logic          in_pend, wait_ans, out_rd, resp_v;
  logic [DW-1:0] in_ctrl, in_data, out_data, answer, rd_data;
  logic [MW-1:0] resp_q;

  // outbound queue
  logic          q_push, q_pop, q_empty, q_full;
  logic [MW-1:0] q_head;

  // bus decode
  logic     wb_go, adr_ok, wr_ctrl, set_rd;
  reg_sel_e sel;
  logic     in_acc;

  assign sel     = reg_sel_e'(wb_adr[3:2]);
  assign adr_ok  = (wb_adr[AW-1:4] == '0) && (wb_adr[1:0] == 2'b00);
  assign wb_go   = wb_stb && !wb_ack && adr_ok;
  assign wr_ctrl = wb_go && wb_we && (sel == REG_CTRL);
  assign q_push  = wr_ctrl && !q_full;
  assign set_rd  = q_push && wb_wdat[DW-3];

  // window replies wait for an empty queue so they never overtake it
  assign in_tready = !in_pend && !resp_v && q_empty;
  assign in_acc    = in_tvalid && in_tready;

  assign out_tvalid = resp_v || !q_empty;
  assign out_tdata  = resp_v ? resp_q : q_head;
  assign q_pop      = out_tready && !resp_v;

  mbx_fifo #(.W(MW), .DEPTH(Q_DEPTH)) q_i (
    .clk(clk), .rst(rst),
    .push(q_push), .wdata({wb_wdat, out_data}),
    .pop(q_pop), .rdata(q_head),
    .empty(q_empty), .full(q_full)
  );

  logic [DW-1:0] status;
  always_comb begin
    status             = '0;
    status[ST_OUT_RD]  = out_rd;
    status[ST_IN_REQ]  = in_pend;
    status[ST_IN_WAIT] = wait_ans;
    status[ST_Q_FULL]  = q_full;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_ack   <= 1'b0;
      wb_rdat  <= '0;
      in_pend  <= 1'b0;
      wait_ans <= 1'b0;
      out_rd   <= 1'b0;
      resp_v   <= 1'b0;
      resp_q   <= '0;
      in_ctrl  <= '0;
      in_data  <= '0;
      out_data <= '0;
      answer   <= '0;
      rd_data  <= '0;
    end else begin
      wb_ack <= wb_stb && !wb_ack;
      if (resp_v && out_tready) resp_v <= 1'b0;

      // bus side first; inbound sets below take priority over bus clears
      if (wb_stb && !wb_ack && !adr_ok && !wb_we) wb_rdat <= '0;
      if (wb_go) begin
        if (wb_we) begin
          case (sel)
            REG_DATA: out_data <= wb_wdat;
            REG_CTRL: begin
              if (q_push && wb_wdat[DW-1]) begin
                wait_ans <= 1'b0;
                answer   <= out_data;
              end
              if (set_rd) out_rd <= 1'b1;
            end
            default: ;
          endcase
        end else begin
          case (sel)
            REG_DATA:  wb_rdat <= in_data;
            REG_CTRL:  begin wb_rdat <= in_ctrl; in_pend <= 1'b0; end
            REG_RDATA: wb_rdat <= rd_data;
            default:   wb_rdat <= status;
          endcase
        end
      end

      if (in_acc) begin
        if (d_resp) begin
          rd_data <= in_tdata[DW-1:0];
          if (!set_rd) out_rd <= 1'b0;
        end else if (d_rd && d_stat) begin
          resp_v <= 1'b1;
          resp_q <= {1'b1, {(MW-2){1'b0}}, wait_ans};
        end else if (d_rd && d_data) begin
          resp_v <= 1'b1;
          resp_q <= {1'b1, {(MW-1-DW){1'b0}}, answer};
        end else if (d_rd || d_wr) begin
          in_pend <= 1'b1;
          in_ctrl <= d_ctrl;
          if (d_wr) in_data  <= in_tdata[DW-1:0];
          else      wait_ans <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int MW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          wb_stb,
  input logic          wb_ack,
  input logic          in_tready,
  input logic          out_tvalid,
  input logic          out_tready,
  input logic [MW-1:0] out_tdata,
  input logic          in_pend,
  input logic          q_full
);
  // R2
  ack_follow_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb && !wb_ack |=> wb_ack);
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);
  // R11
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata));
  // R3
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    in_pend |-> !in_tready);
  // R8
  full_valid_chk: assert property (@(posedge clk) disable iff (rst)
    q_full |-> out_tvalid);
endmodule

bind msg_wb_mailbox mbx_chk #(.MW(2*DW)) chk_i (
  .clk(clk), .rst(rst), .wb_stb(wb_stb), .wb_ack(wb_ack),
  .in_tready(in_tready), .out_tvalid(out_tvalid), .out_tready(out_tready),
  .out_tdata(out_tdata), .in_pend(in_pend), .q_full(q_full)
);

// File: tb/msg_wb_mailbox_tb_top.sv
`timescale 1ns/1ps
module msg_wb_mailbox_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wb_stb = 1'b0, wb_we = 1'b0;
  logic [15:0] wb_adr = '0;
  logic [31:0] wb_wdat = '0;
  logic        wb_ack;
  logic [31:0] wb_rdat;
  logic [63:0] in_tdata = '0;
  logic        in_tvalid = 1'b0;
  logic        in_tready;
  logic [63:0] out_tdata;
  logic        out_tvalid;
  logic        out_tready = 1'b0;

  always #2.5 clk = ~clk;

  msg_wb_mailbox dut_i (
    .clk(clk), .rst(rst), .wb_stb(wb_stb), .wb_we(wb_we), .wb_adr(wb_adr),
    .wb_wdat(wb_wdat), .wb_ack(wb_ack), .wb_rdat(wb_rdat),
    .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready),
    .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready)
  );

  int errors = 0, checks = 0, rx_n = 0;
  logic [63:0] exp_q[$];
  int rdy_mode = 1; // 0 random, 1 high, 2 low

  // reference state
  logic m_in_pend = 0, m_wait = 0, m_out_rd = 0;
  logic [31:0] m_ctrl = 0, m_in_data = 0, m_out_data = 0, m_answer = 0, m_rd_data = 0;

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_wr(input logic [19:0] a, input logic [31:0] d);
    return {3'b010, 9'h0, a, d};
  endfunction
  function automatic logic [63:0] mk_rd(input logic [19:0] a);
    return {3'b001, 9'h0, a, 32'h0};
  endfunction
  function automatic logic [63:0] mk_rsp(input logic [31:0] d);
    return {1'b1, 31'h0, d};
  endfunction
  function automatic logic [31:0] ctrl_of(input logic [2:0] f, input logic [19:0] a);
    return {f, 13'h0, a[15:0]};
  endfunction
  function automatic logic [31:0] st_of(input logic full);
    return {27'h0, full, 1'b0, m_wait, m_in_pend, m_out_rd};
  endfunction

  // output readiness, changed away from both edges
  always @(posedge clk) begin
    #1;
    case (rdy_mode)
      0:       out_tready = $urandom_range(0, 1) == 1;
      1:       out_tready = 1'b1;
      default: out_tready = 1'b0;
    endcase
  end

  // outbound monitor; the transfer happens at the following rising edge
  always @(negedge clk) begin
    if (!rst && out_tvalid && out_tready) begin
      rx_n++;
      if (exp_q.size() == 0) chk(1'b0, "R5/R9 unexpected outbound", out_tdata, 64'h0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        chk(out_tdata == e, "R5/R9/R10 outbound message", out_tdata, e);
      end
    end
  end

  task automatic wb_xfer(input logic we, input logic [15:0] a, input logic [31:0] d, output logic [31:0] rd);
    @(negedge clk);
    wb_stb = 1'b1; wb_we = we; wb_adr = a; wb_wdat = d;
    @(negedge clk);
    chk(wb_ack === 1'b1, "R2 ack after strobe", {63'h0, wb_ack}, 64'h1);
    rd = wb_rdat;
    wb_stb = 1'b0; wb_we = 1'b0;
  endtask

  task automatic wb_check(input logic [15:0] a, input logic [31:0] e, input string tag);
    logic [31:0] r;
    wb_xfer(1'b0, a, 32'h0, r);
    chk(r == e, tag, {32'h0, r}, {32'h0, e});
  endtask

  task automatic wb_write(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] r;
    wb_xfer(1'b1, a, d, r);
  endtask

  task automatic s_send(input logic [63:0] m);
    @(negedge clk);
    in_tdata = m; in_tvalid = 1'b1;
    while (!in_tready) @(negedge clk);
    @(negedge clk);
    in_tvalid = 1'b0;
  endtask

  task automatic drain();
    rdy_mode = 1;
    while (exp_q.size() != 0 || out_tvalid) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(out_tvalid == 1'b0, "R1 out_tvalid after reset", {63'h0, out_tvalid}, 64'h0);
    chk(in_tready == 1'b1, "R1 in_tready after reset", {63'h0, in_tready}, 64'h1);
    wb_check(16'hC, 32'h0, "R1 status after reset");
    @(negedge clk);
    chk(wb_ack == 1'b0, "R2 ack is one cycle", {63'h0, wb_ack}, 64'h0);

    // R3 inbound write
    s_send(mk_wr(20'h7B000, 32'h1234_5678));
    m_in_pend = 1; m_ctrl = ctrl_of(3'b010, 20'h7B000); m_in_data = 32'h1234_5678;
    @(negedge clk);
    chk(in_tready == 1'b0, "R3 busy while request pending", {63'h0, in_tready}, 64'h0);
    wb_check(16'hC, 32'h2, "R3 status after inbound write");
    wb_check(16'h0, 32'h1234_5678, "R3 inbound data");
    wb_check(16'h4, 32'h4000_B000, "R3 inbound control");
    m_in_pend = 0;
    wb_check(16'hC, 32'h0, "R3 status after consuming");

    // R4/R6/R9/R10 inbound read and answer
    s_send(mk_rd(20'h1A000));
    m_in_pend = 1; m_wait = 1;
    wb_check(16'hC, 32'h6, "R4 status after inbound read");
    wb_check(16'h4, 32'h2000_A000, "R4 inbound read control");
    m_in_pend = 0;
    exp_q.push_back(mk_rsp(32'h1));
    s_send(mk_rd(20'h6A000)); // R9 waiting
    drain();
    wb_write(16'h0, 32'hDEAD_BEEF);
    m_out_data = 32'hDEAD_BEEF;
    exp_q.push_back({32'h8000_0000, 32'hDEAD_BEEF});
    wb_write(16'h4, 32'h8000_0000);
    m_wait = 0; m_answer = 32'hDEAD_BEEF;
    wb_check(16'hC, 32'h0, "R6 status after answer");
    exp_q.push_back(mk_rsp(32'h0));
    s_send(mk_rd(20'h6A000)); // R9 answered
    s_send(mk_wr(20'h7B004, 32'h0BAD_0BAD));
    m_in_pend = 1; m_in_data = 32'h0BAD_0BAD; m_ctrl = ctrl_of(3'b010, 20'h7B004);
    wb_check(16'h4, m_ctrl, "R3 control second write");
    m_in_pend = 0;
    exp_q.push_back(mk_rsp(32'hDEAD_BEEF));
    s_send(mk_rd(20'h7A000)); // R10 unchanged by later write
    drain();

    // R5 data-only write emits nothing
    begin
      int n0;
      n0 = rx_n;
      wb_write(16'h0, 32'h00BE_EF00);
      m_out_data = 32'h00BE_EF00;
      repeat (6) @(negedge clk);
      chk(rx_n == n0, "R5 data write emits nothing", 64'(rx_n), 64'(n0));
    end
    exp_q.push_back({32'h4000_0200, 32'h00BE_EF00});
    wb_write(16'h4, 32'h4000_0200);
    drain();

    // R7 outbound read and response
    exp_q.push_back({32'h2000_0400, 32'h00BE_EF00});
    wb_write(16'h4, 32'h2000_0400);
    m_out_rd = 1;
    drain();
    wb_check(16'hC, 32'h1, "R7 status with outbound read");
    s_send(mk_rsp(32'hACE0_6666));
    m_out_rd = 0; m_rd_data = 32'hACE0_6666;
    wb_check(16'hC, 32'h0, "R7 status after response");
    wb_check(16'h8, 32'hACE0_6666, "R7 response data");

    // R12 read-only registers ignore writes
    wb_write(16'h8, 32'h5555_5555);
    wb_write(16'hC, 32'hFFFF_FFFF);
    wb_check(16'h8, 32'hACE0_6666, "R12 response data after write");
    wb_check(16'hC, 32'h0, "R12 status after write");

    // random mix under random back-pressure
    rdy_mode = 0;
    for (int i = 0; i < 400; i++) begin
      int op;
      logic [19:0] a;
      logic [31:0] d;
      op = $urandom_range(0, 9);
      a  = {4'h1, 4'($urandom_range(0, 15)), 12'($urandom)};
      d  = $urandom;
      case (op)
        0: if (!m_in_pend) begin
             s_send(mk_wr(a, d));
             m_in_pend = 1; m_ctrl = ctrl_of(3'b010, a); m_in_data = d;
           end
        1: if (!m_in_pend) begin
             s_send(mk_rd(a));
             m_in_pend = 1; m_wait = 1; m_ctrl = ctrl_of(3'b001, a);
           end
        2: begin wb_check(16'h4, m_ctrl, "R3/R4 random control"); m_in_pend = 0; end
        3: wb_check(16'h0, m_in_data, "R3 random data");
        4: begin wb_write(16'h0, d); m_out_data = d; end
        5: begin
             exp_q.push_back({ctrl_of(3'b010, a), m_out_data});
             wb_write(16'h4, ctrl_of(3'b010, a));
           end
        6: begin
             exp_q.push_back({32'h8000_0000, m_out_data});
             wb_write(16'h4, 32'h8000_0000);
             m_wait = 0; m_answer = m_out_data;
           end
        7: if (!m_in_pend) begin
             if (d[0]) begin exp_q.push_back(mk_rsp({31'h0, m_wait})); s_send(mk_rd(20'h6A000 | {8'h0, a[11:0]})); end
             else      begin exp_q.push_back(mk_rsp(m_answer));        s_send(mk_rd(20'h7A000 | {8'h0, a[11:0]})); end
           end
        8: begin
             if (d[1]) begin
               exp_q.push_back({ctrl_of(3'b001, a), m_out_data});
               wb_write(16'h4, ctrl_of(3'b001, a));
               m_out_rd = 1;
             end else if (!m_in_pend) begin
               s_send(mk_rsp(d));
               m_out_rd = 0; m_rd_data = d;
             end
           end
        default: begin
          wb_check(16'hC, st_of(1'b0), "R3/R4/R6/R7 random status");
          wb_check(16'h8, m_rd_data, "R7 random response data");
        end
      endcase
    end
    drain();

    // R8 queue flood with the stream stalled
    rdy_mode = 2;
    repeat (3) @(negedge clk);
    wb_write(16'h0, 32'h0000_F00D);
    m_out_data = 32'h0000_F00D;
    for (int k = 0; k < 66; k++) begin
      if (k < 64) exp_q.push_back({32'h2000_0400, 32'h0000_F00D});
      wb_write(16'h4, 32'h2000_0400);
    end
    m_out_rd = 1;
    wb_check(16'hC, st_of(1'b1), "R8 status with full queue");
    begin
      logic [63:0] s0;
      @(negedge clk);
      s0 = out_tdata;
      repeat (4) @(negedge clk);
      chk(out_tvalid && out_tdata == s0, "R11 held while stalled", out_tdata, s0);
    end
    begin
      int n0;
      n0 = rx_n;
      drain();
      chk(rx_n - n0 == 64, "R8 drained count", 64'(rx_n - n0), 64'd64);
    end
    wb_check(16'hC, st_of(1'b0), "R8 status after drain");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all expected messages seen", 64'(exp_q.size()), 64'h0);
    finish_run();
  end
endmodule